// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block sits between a timer's compare logic and a general-purpose I/O pad. Each channel keeps a one-bit output compare state register that changes on a compare match strobe (or a software force strobe) according to a two-bit action mode. The actions are toggle, clear and set. The block also chooses what the pad drives. Any nonzero mode hands the pad value to the compare state. Mode zero leaves the pad with the port's own data bit.

The compare state is a register of its own, separate from the pad. It can be preset with the force strobe while the direction bit still holds the pad as an input. When the direction bit is later switched to output, the prepared level appears at once. The pad's output enable follows the direction bit and nothing else. The number of channels is a parameter, and every channel behaves independently.

Top module: `timer_oc_pin`

## Requirements
- R1: A synchronous active-high reset clears every compare state register to 0.
- R2: With mode 2'b01 (toggle), a strobe inverts the compare state at the rising edge where the strobe is high.
- R3: With mode 2'b10 (clear), a strobe makes the compare state 0 at that edge.
- R4: With mode 2'b11 (set), a strobe makes the compare state 1 at that edge.
- R5: With mode 2'b00 (disconnected), strobes leave the compare state unchanged, and the pad value equals the port data bit.
- R6: With any nonzero mode, the pad value equals the compare state. It is combinational, so a mode change shows on the pad in the same cycle.
- R7: The pad output enable equals the direction bit (1 = output) in every mode, so a state preset while it is 0 is not driven.
- R8: The force strobe has the same effect as a compare match. A match and a force in the same cycle produce one action, so toggle inverts only once.
- R9: Channels are independent. Strobes and mode on one channel leave the others unchanged.
- R10: With no strobe, the compare state holds its value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match_i | input | NCH | Compare match strobe per channel |
| force_i | input | NCH | Force-compare strobe per channel |
| mode_i | input | NCH x 2 | Action mode per channel: 00 off, 01 toggle, 10 clear, 11 set |
| port_data_i | input | NCH | Port data register bit per channel |
| port_dir_i | input | NCH | Direction bit per channel, 1 = output |
| pin_out_o | output | NCH | Value offered to the pad driver |
| pin_oe_o | output | NCH | Pad driver enable |

## Verification
The hardest situation to reach from the ports is a compare state that was changed while it could not be seen. This covers a preset made with the direction bit at input, and a value held through a stretch of mode 00 while the pad shows port data. The stimulus walks through those phases in order. It then switches to a nonzero mode with no strobe and checks that the hidden value surfaces unchanged. It also drives a simultaneous match and force under toggle, which must produce a single inversion, and it strobes one channel while watching the other.

// File: rtl/tocp_pkg.sv
package tocp_pkg;

    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_mode_e;

    typedef struct packed {
        logic load;
        logic value;
    } oc_action_t;

    function automatic oc_action_t oc_decide(input oc_mode_e mode,
                                             input logic strobe,
                                             input logic cur);
        oc_action_t act;
        act.load  = 1'b0;
        act.value = cur;
        if (strobe) begin
            unique case (mode)
                OC_TOGGLE: begin act.load = 1'b1; act.value = ~cur; end
                OC_CLEAR:  begin act.load = 1'b1; act.value = 1'b0; end
                OC_SET:    begin act.load = 1'b1; act.value = 1'b1; end
                default:   begin act.load = 1'b0; act.value = cur;  end
            endcase
        end
        return act;
    endfunction

endpackage

// File: rtl/tocp_decode.sv
module tocp_decode
    import tocp_pkg::*;
(
    input  logic       match_i,
    input  logic       force_i,
    input  logic [1:0] mode_i,
    input  logic       cur_i,
    output oc_action_t act_o
);
    logic strobe;
    assign strobe = match_i | force_i;

    always_comb begin
        act_o = oc_decide(oc_mode_e'(mode_i), strobe, cur_i);
    end
endmodule

// File: rtl/tocp_state.sv
module tocp_state
    import tocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  oc_action_t act_i,
    output logic       state_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= 1'b0;
        end else if (act_i.load) begin
            state_o <= act_i.value;
        end
    end
endmodule

// File: rtl/tocp_pinmux.sv
module tocp_pinmux (
    input  logic       state_i,
    input  logic [1:0] mode_i,
    input  logic       data_i,
    input  logic       dir_i,
    output logic       out_o,
    output logic       oe_o
);
    logic take_over;
    assign take_over = |mode_i;

    always_comb begin
        out_o = take_over ? state_i : data_i;
        oe_o  = dir_i;
    end
endmodule

// File: rtl/timer_oc_pin.sv
module timer_oc_pin
    import tocp_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      cmp_match_i,
    input  logic [NCH-1:0]      force_i,
    input  logic [NCH-1:0][1:0] mode_i,
    input  logic [NCH-1:0]      port_data_i,
    input  logic [NCH-1:0]      port_dir_i,
    output logic [NCH-1:0]      pin_out_o,
    output logic [NCH-1:0]      pin_oe_o
);
    logic [NCH-1:0] oc_state;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        oc_action_t act;

        tocp_decode u_dec (
            .match_i (cmp_match_i[ch]),
            .force_i (force_i[ch]),
            .mode_i  (mode_i[ch]),
            .cur_i   (oc_state[ch]),
            .act_o   (act)
        );

        tocp_state u_reg (
            .clk     (clk),
            .rst     (rst),
            .act_i   (act),
            .state_o (oc_state[ch])
        );

        tocp_pinmux u_mux (
            .state_i (oc_state[ch]),
            .mode_i  (mode_i[ch]),
            .data_i  (port_data_i[ch]),
            .dir_i   (port_dir_i[ch]),
            .out_o   (pin_out_o[ch]),
            .oe_o    (pin_oe_o[ch])
        );
    end
endmodule

// File: rtl/timer_oc_pin_chk.sv
module timer_oc_pin_chk #(
    parameter int NCH = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NCH-1:0]      cmp_match_i,
    input logic [NCH-1:0]      force_i,
    input logic [NCH-1:0][1:0] mode_i,
    input logic [NCH-1:0]      port_data_i,
    input logic [NCH-1:0]      port_dir_i,
    input logic [NCH-1:0]      pin_out_o,
    input logic [NCH-1:0]      pin_oe_o,
    input logic [NCH-1:0]      oc_state
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (oc_state == '0));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        logic strobe;
        assign strobe = cmp_match_i[ch] | force_i[ch];

        // R2 and R8
        toggle_once_chk: assert property (@(posedge clk) disable iff (rst)
            (strobe && mode_i[ch] == 2'b01) |=> (oc_state[ch] != $past(oc_state[ch])));

        // R3
        clear_act_chk: assert property (@(posedge clk) disable iff (rst)
            (strobe && mode_i[ch] == 2'b10) |=> !oc_state[ch]);

        // R4
        set_act_chk: assert property (@(posedge clk) disable iff (rst)
            (strobe && mode_i[ch] == 2'b11) |=> oc_state[ch]);

        // R5 and R10
        hold_state_chk: assert property (@(posedge clk) disable iff (rst)
            (!strobe || mode_i[ch] == 2'b00) |=> $stable(oc_state[ch]));

        // R5
        port_data_route_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_i[ch] == 2'b00) |-> (pin_out_o[ch] == port_data_i[ch]));

        // R6
        state_route_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_i[ch] != 2'b00) |-> (pin_out_o[ch] == oc_state[ch]));

        // R7
        dir_gate_chk: assert property (@(posedge clk) disable iff (rst)
            pin_oe_o[ch] == port_dir_i[ch]);
    end
endmodule

bind timer_oc_pin timer_oc_pin_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmp_match_i (cmp_match_i),
    .force_i     (force_i),
    .mode_i      (mode_i),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .oc_state    (oc_state)
);

// File: tb/tb_timer_oc_pin.sv
`timescale 1ns/1ps
module tb_timer_oc_pin;
    localparam int NCH = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic [NCH-1:0]      cmp_match_i;
    logic [NCH-1:0]      force_i;
    logic [NCH-1:0][1:0] mode_i;
    logic [NCH-1:0]      port_data_i;
    logic [NCH-1:0]      port_dir_i;
    logic [NCH-1:0]      pin_out_o;
    logic [NCH-1:0]      pin_oe_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    timer_oc_pin #(.NCH(NCH)) dut (.*);

    // vector: {tag[3:0], mode[1:0], match, force, data, dir, exp_out, exp_oe}
    localparam int NV = 16;
    localparam logic [11:0] VEC [NV] = '{
        {4'd1,  2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R1 state 0 after reset
        {4'd4,  2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 set
        {4'd2,  2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 toggle to 0
        {4'd8,  2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 force toggles
        {4'd8,  2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 both: one toggle
        {4'd10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 hold
        {4'd4,  2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 set via force
        {4'd3,  2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 clear
        {4'd3,  2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 clear again
        {4'd5,  2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 pin = data
        {4'd5,  2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 pin = data
        {4'd7,  2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 state kept 0, R7 oe off
        {4'd7,  2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 preset while input
        {4'd7,  2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 oe on, data shown
        {4'd6,  2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 preset surfaces
        {4'd6,  2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}  // R6 any nonzero mode
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmp_match_i = '0; force_i = '0; mode_i = '0;
        port_data_i = '0; port_dir_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // channel 1 parked in clear mode with no strobes
        mode_i[1] = 2'b10;
        port_dir_i[1] = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[11:8], i);
            mode_i[0]      = v[7:6];
            cmp_match_i[0] = v[5];
            force_i[0]     = v[4];
            port_data_i[0] = v[3];
            port_dir_i[0]  = v[2];
            @(negedge clk);
            check(tag, pin_out_o[0], v[1]);
            check(tag, pin_oe_o[0],  v[0]);
            cmp_match_i[0] = 1'b0;
            force_i[0] = 1'b0;
        end

        // R9: channel 1 untouched by channel 0 activity
        check("R9 ch1 state", pin_out_o[1], 1'b0);
        mode_i[1] = 2'b11;
        cmp_match_i[1] = 1'b1;
        @(negedge clk);
        cmp_match_i[1] = 1'b0;
        check("R9 ch1 set", pin_out_o[1], 1'b1);
        check("R9 ch0 held", pin_out_o[0], 1'b1);

        // R6: mode change visible without a clock edge
        mode_i[0] = 2'b00;
        port_data_i[0] = 1'b0;
        #1;
        check("R6 same cycle to data", pin_out_o[0], 1'b0);
        mode_i[0] = 2'b10;
        #1;
        check("R6 same cycle to state", pin_out_o[0], 1'b1);

        // R1: reset in mid run clears both states
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mode_i[0] = 2'b11;
        mode_i[1] = 2'b11;
        #1;
        check("R1 ch0 cleared", pin_out_o[0], 1'b0);
        check("R1 ch1 cleared", pin_out_o[1], 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule